// File: doc/BRIEF.md
# Multi-source snoop invalidation unit

This block keeps the valid bits of a write-through, set-associative L1 cache coherent with stores made elsewhere in the system. It holds the tag and valid arrays of the cache. Several snoop sources report their stores to it: one per other processor, and one DMA engine at the highest source index. The cache is write-through, so a store seen on a snoop port never needs a write-back. At most it removes a line by clearing its valid bit.

Hit detection runs in parallel. Each source's snoop is compared against the stored tag of every way in the addressed set. A source with at least one valid matching way parks its set index and way mask in a one-entry pending register. The valid array has a single clear port, and pending entries reach it one per cycle in round-robin order. A source whose entry is still waiting sees its busy output high and must hold back its next snoop. A snoop that matches nothing finishes in the detect stage and takes no clear slot.

The cache's refill path writes tags and sets valid bits through the fill port. The lookup port gives the per-way hit result for any set and tag. A flush input wipes every valid bit and every pending entry in one cycle.

Top module: `snpinv_unit`

## Requirements
- R1: After reset all busy outputs are low and every lookup reports no hit.
- R2: After the clock edge that samples a refill of set S, way W, tag T, a lookup of (S, T) has lkp_hit_o high and bit W of lkp_ways_o set (bit index equals way number).
- R3: A snoop on any source whose set and tag match a valid way raises that source's busy output from the clock edge that samples the snoop. Source indices 0..N-1 are processors and index N is the DMA engine. If no other entry is pending, busy falls at the next edge and the matched line then misses on lookup.
- R4: A snoop hit clears every matching way of the addressed set. Lines in other sets, and lines with other tags, keep their valid state.
- R5: A snoop raises no busy output and changes no line when its tag differs, when its set differs, or when the matching way is already invalid.
- R6: With several entries pending, at most one source is cleared per clock edge, so busy bits fall one per cycle.
- R7: The clear port goes to the first pending source at or after a round-robin pointer. The pointer then moves to the index after the granted source. Reset sets the pointer to 0.
- R8: A snoop presented on a source while its busy output is high is ignored. The line it names stays valid.
- R9: When a refill and a snoop clear target the same set and way on the same edge, the clear wins and the line ends invalid.
- R10: A flush clears all valid bits and drops all pending entries at one edge. A dropped entry never clears a line refilled afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_i | input | 1 | Invalidate the whole cache and drop pending snoops |
| snp_valid_i | input | NSRC | Per-source snoop strobe (index NSRC-1 is DMA) |
| snp_set_i | input | NSRC*SET_W | Per-source set index, source s at bits [s*SET_W +: SET_W] |
| snp_tag_i | input | NSRC*TAG_W | Per-source tag, source s at bits [s*TAG_W +: TAG_W] |
| snp_busy_o | output | NSRC | Per-source busy: pending entry occupied |
| fill_en_i | input | 1 | Refill write strobe |
| fill_set_i | input | SET_W | Refill set index |
| fill_way_i | input | WAY_W | Refill way number |
| fill_tag_i | input | TAG_W | Refill tag |
| lkp_set_i | input | SET_W | Lookup set index |
| lkp_tag_i | input | TAG_W | Lookup tag |
| lkp_hit_o | output | 1 | Lookup hits in some way |
| lkp_ways_o | output | NUM_WAYS | Per-way lookup hit mask |

## Verification
The hardest state to reach is a source whose entry stays pending for more than one cycle, because a sole entry is cleared at the very next edge. The stimulus first sends one snoop alone, which moves the pointer to 1. It then captures snoops on sources 0 and 2 together, so source 2 is served first and source 0 stays busy for a second cycle. That second cycle is where the ignored-snoop check is placed. The refill-versus-clear collision is set up by timing a refill into the single cycle in which a lone entry is pending.

// File: rtl/snpinv_pkg.sv
package snpinv_pkg;

    // Default geometry of the snooped cache
    localparam int unsigned DEF_CPUS  = 2;
    localparam int unsigned DEF_SETS  = 8;
    localparam int unsigned DEF_WAYS  = 2;
    localparam int unsigned DEF_TAG_W = 8;

    // Index that follows cur in a ring of n sources
    function automatic int unsigned rr_next(input int unsigned cur, input int unsigned n);
        return (cur + 1 >= n) ? 0 : cur + 1;
    endfunction

    // Wrap an offset from the ring pointer back into range
    function automatic int unsigned ring_add(input int unsigned base, input int unsigned off,
                                             input int unsigned n);
        int unsigned sum;
        sum = base + off;
        return (sum >= n) ? sum - n : sum;
    endfunction

endpackage

// File: rtl/snpinv_tag_store.sv
module snpinv_tag_store
    import snpinv_pkg::*;
#(
    parameter int unsigned SETS  = DEF_SETS,
    parameter int unsigned WAYS  = DEF_WAYS,
    parameter int unsigned TAG_W = DEF_TAG_W,
    parameter int unsigned SET_W = $clog2(SETS),
    parameter int unsigned WAY_W = $clog2(WAYS)
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   flush,
    input  logic                                   fill_en,
    input  logic [SET_W-1:0]                       fill_set,
    input  logic [WAY_W-1:0]                       fill_way,
    input  logic [TAG_W-1:0]                       fill_tag,
    input  logic                                   clr_en,
    input  logic [SET_W-1:0]                       clr_set,
    input  logic [WAYS-1:0]                        clr_mask,
    output logic [SETS-1:0][WAYS-1:0]              valid_q,
    output logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]   tag_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            tag_q   <= '0;
        end else begin
            if (fill_en) begin
                tag_q[fill_set][fill_way] <= fill_tag;
            end
            if (flush) begin
                valid_q <= '0;
            end else begin
                for (int s = 0; s < int'(SETS); s++) begin
                    for (int w = 0; w < int'(WAYS); w++) begin
                        if (fill_en && fill_set == SET_W'(s) && fill_way == WAY_W'(w)) begin
                            valid_q[s][w] <= 1'b1;
                        end
                        // Placed after the refill so that a clear wins
                        if (clr_en && clr_set == SET_W'(s) && clr_mask[w]) begin
                            valid_q[s][w] <= 1'b0;
                        end
                    end
                end
            end
        end
    end

endmodule

// File: rtl/snpinv_detect.sv
module snpinv_detect
    import snpinv_pkg::*;
#(
    parameter int unsigned NSRC  = DEF_CPUS + 1,
    parameter int unsigned SETS  = DEF_SETS,
    parameter int unsigned WAYS  = DEF_WAYS,
    parameter int unsigned TAG_W = DEF_TAG_W,
    parameter int unsigned SET_W = $clog2(SETS)
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   flush,
    input  logic [NSRC-1:0]                        snp_vld,
    input  logic [NSRC-1:0][SET_W-1:0]             snp_set,
    input  logic [NSRC-1:0][TAG_W-1:0]             snp_tag,
    input  logic [SETS-1:0][WAYS-1:0]              valid_q,
    input  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]   tag_q,
    input  logic [NSRC-1:0]                        gnt,
    output logic [NSRC-1:0]                        pend_vld,
    output logic [NSRC-1:0][SET_W-1:0]             pend_set,
    output logic [NSRC-1:0][WAYS-1:0]              pend_mask
);

    typedef struct packed {
        logic [SET_W-1:0] set;
        logic [WAYS-1:0]  mask;
    } pend_t;

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        logic [WAYS-1:0] hit;
        logic            occ_q;
        pend_t           ent_q;

        // Stage one: every way of the addressed set against the snoop tag
        always_comb begin
            for (int w = 0; w < int'(WAYS); w++) begin
                hit[w] = valid_q[snp_set[s]][w] && (tag_q[snp_set[s]][w] == snp_tag[s]);
            end
        end

        always_ff @(posedge clk) begin
            if (rst || flush) begin
                occ_q <= 1'b0;
                ent_q <= '0;
            end else if (gnt[s]) begin
                occ_q <= 1'b0;
            end else if (snp_vld[s] && !occ_q && (|hit)) begin
                occ_q      <= 1'b1;
                ent_q.set  <= snp_set[s];
                ent_q.mask <= hit;
            end
        end

        assign pend_vld[s]  = occ_q;
        assign pend_set[s]  = ent_q.set;
        assign pend_mask[s] = ent_q.mask;
    end

endmodule

// File: rtl/snpinv_rr_arb.sv
module snpinv_rr_arb
    import snpinv_pkg::*;
#(
    parameter int unsigned N     = DEF_CPUS + 1,
    parameter int unsigned IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     req,
    output logic [N-1:0]     gnt,
    output logic             gnt_vld,
    output logic [IDX_W-1:0] gnt_idx
);

    logic [IDX_W-1:0] ptr_q;
    int unsigned      cand;

    // Scan from the far end so the candidate nearest the pointer is kept
    always_comb begin
        gnt_vld = 1'b0;
        gnt_idx = '0;
        cand    = 0;
        for (int k = int'(N) - 1; k >= 0; k--) begin
            cand = ring_add(int'(ptr_q), k, N);
            if (req[cand]) begin
                gnt_vld = 1'b1;
                gnt_idx = IDX_W'(cand);
            end
        end
        gnt = '0;
        gnt[gnt_idx] = gnt_vld;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (gnt_vld) begin
            ptr_q <= IDX_W'(rr_next(int'(gnt_idx), N));
        end
    end

endmodule

// File: rtl/snpinv_unit.sv
module snpinv_unit
    import snpinv_pkg::*;
#(
    parameter int unsigned NUM_CPUS  = DEF_CPUS,
    parameter int unsigned NUM_SETS  = DEF_SETS,
    parameter int unsigned NUM_WAYS  = DEF_WAYS,
    parameter int unsigned TAG_W     = DEF_TAG_W,
    localparam int unsigned NSRC     = NUM_CPUS + 1,
    localparam int unsigned SET_W    = $clog2(NUM_SETS),
    localparam int unsigned WAY_W    = $clog2(NUM_WAYS),
    localparam int unsigned IDX_W    = $clog2(NSRC)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    flush_i,
    input  logic [NSRC-1:0]         snp_valid_i,
    input  logic [NSRC*SET_W-1:0]   snp_set_i,
    input  logic [NSRC*TAG_W-1:0]   snp_tag_i,
    output logic [NSRC-1:0]         snp_busy_o,
    input  logic                    fill_en_i,
    input  logic [SET_W-1:0]        fill_set_i,
    input  logic [WAY_W-1:0]        fill_way_i,
    input  logic [TAG_W-1:0]        fill_tag_i,
    input  logic [SET_W-1:0]        lkp_set_i,
    input  logic [TAG_W-1:0]        lkp_tag_i,
    output logic                    lkp_hit_o,
    output logic [NUM_WAYS-1:0]     lkp_ways_o
);

    logic [NSRC-1:0][SET_W-1:0]                   snp_set_a;
    logic [NSRC-1:0][TAG_W-1:0]                   snp_tag_a;
    logic [NUM_SETS-1:0][NUM_WAYS-1:0]            valid_q;
    logic [NUM_SETS-1:0][NUM_WAYS-1:0][TAG_W-1:0] tag_q;
    logic [NSRC-1:0]                              pend_vld;
    logic [NSRC-1:0][SET_W-1:0]                   pend_set;
    logic [NSRC-1:0][NUM_WAYS-1:0]                pend_mask;
    logic [NSRC-1:0]                              gnt;
    logic                                         gnt_vld;
    logic [IDX_W-1:0]                             gnt_idx;
    logic                                         clr_en;
    logic [SET_W-1:0]                             clr_set;
    logic [NUM_WAYS-1:0]                          clr_mask;

    assign snp_set_a = snp_set_i;
    assign snp_tag_a = snp_tag_i;

    snpinv_tag_store #(
        .SETS(NUM_SETS), .WAYS(NUM_WAYS), .TAG_W(TAG_W), .SET_W(SET_W), .WAY_W(WAY_W)
    ) u_store (
        .clk(clk), .rst(rst), .flush(flush_i),
        .fill_en(fill_en_i), .fill_set(fill_set_i), .fill_way(fill_way_i), .fill_tag(fill_tag_i),
        .clr_en(clr_en), .clr_set(clr_set), .clr_mask(clr_mask),
        .valid_q(valid_q), .tag_q(tag_q)
    );

    snpinv_detect #(
        .NSRC(NSRC), .SETS(NUM_SETS), .WAYS(NUM_WAYS), .TAG_W(TAG_W), .SET_W(SET_W)
    ) u_detect (
        .clk(clk), .rst(rst), .flush(flush_i),
        .snp_vld(snp_valid_i), .snp_set(snp_set_a), .snp_tag(snp_tag_a),
        .valid_q(valid_q), .tag_q(tag_q), .gnt(gnt),
        .pend_vld(pend_vld), .pend_set(pend_set), .pend_mask(pend_mask)
    );

    snpinv_rr_arb #(
        .N(NSRC), .IDX_W(IDX_W)
    ) u_arb (
        .clk(clk), .rst(rst), .req(pend_vld),
        .gnt(gnt), .gnt_vld(gnt_vld), .gnt_idx(gnt_idx)
    );

    // Single write port into the valid array
    always_comb begin
        clr_en   = gnt_vld;
        clr_set  = pend_set[gnt_idx];
        clr_mask = pend_mask[gnt_idx];
    end

    always_comb begin
        for (int w = 0; w < int'(NUM_WAYS); w++) begin
            lkp_ways_o[w] = valid_q[lkp_set_i][w] && (tag_q[lkp_set_i][w] == lkp_tag_i);
        end
        lkp_hit_o = |lkp_ways_o;
    end

    assign snp_busy_o = pend_vld;

endmodule

// File: rtl/snpinv_unit_chk.sv
module snpinv_unit_chk #(
    parameter int unsigned NSRC  = 3,
    parameter int unsigned SETS  = 8,
    parameter int unsigned WAYS  = 2,
    parameter int unsigned SET_W = 3,
    parameter int unsigned WAY_W = 1
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      flush,
    input logic [NSRC-1:0]           snp_valid,
    input logic [NSRC-1:0]           busy,
    input logic [NSRC-1:0]           gnt,
    input logic                      clr_en,
    input logic [SET_W-1:0]          clr_set,
    input logic [WAYS-1:0]           clr_mask,
    input logic                      fill_en,
    input logic [SET_W-1:0]          fill_set,
    input logic [WAY_W-1:0]          fill_way,
    input logic [SETS-1:0][WAYS-1:0] valid_q
);

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (busy == '0));

    assert_clear_lands_R4: assert property (@(posedge clk) disable iff (rst)
        (clr_en && !flush) |=> ((valid_q[$past(clr_set)] & $past(clr_mask)) == '0));

    assert_one_grant_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));

    assert_one_release_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(flush) && !$past(rst)) |-> ($countones($past(busy) & ~busy) <= 1));

    assert_clear_beats_fill_R9: assert property (@(posedge clk) disable iff (rst)
        (clr_en && fill_en && !flush && clr_set == fill_set && clr_mask[fill_way])
        |=> !valid_q[$past(fill_set)][$past(fill_way)]);

    assert_flush_drops_R10: assert property (@(posedge clk) disable iff (rst)
        flush |=> (busy == '0));

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        // R3: a lone pending entry is released at the next edge
        assert_sole_served_R3: assert property (@(posedge clk) disable iff (rst)
            (busy == (NSRC'(1) << s)) |=> !busy[s]);

        // R5: busy only ever rises because a snoop was presented
        assert_busy_origin_R5: assert property (@(posedge clk) disable iff (rst)
            $rose(busy[s]) |-> $past(snp_valid[s]));
    end

endmodule

bind snpinv_unit snpinv_unit_chk #(
    .NSRC(NSRC), .SETS(NUM_SETS), .WAYS(NUM_WAYS), .SET_W(SET_W), .WAY_W(WAY_W)
) u_chk (
    .clk(clk), .rst(rst), .flush(flush_i), .snp_valid(snp_valid_i), .busy(snp_busy_o),
    .gnt(gnt), .clr_en(clr_en), .clr_set(clr_set), .clr_mask(clr_mask),
    .fill_en(fill_en_i), .fill_set(fill_set_i), .fill_way(fill_way_i), .valid_q(valid_q)
);

// File: tb/snpinv_unit_tb.sv
module snpinv_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush_i = 1'b0;
    logic [2:0]  snp_valid = '0;
    logic [8:0]  snp_set = '0;
    logic [23:0] snp_tag = '0;
    logic [2:0]  busy;
    logic        fill_en = 1'b0;
    logic [2:0]  fill_set = '0;
    logic        fill_way = 1'b0;
    logic [7:0]  fill_tag = '0;
    logic [2:0]  lkp_set = '0;
    logic [7:0]  lkp_tag = '0;
    logic        lkp_hit;
    logic [1:0]  lkp_ways;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    snpinv_unit u_dut (
        .clk(clk), .rst(rst), .flush_i(flush_i),
        .snp_valid_i(snp_valid), .snp_set_i(snp_set), .snp_tag_i(snp_tag), .snp_busy_o(busy),
        .fill_en_i(fill_en), .fill_set_i(fill_set), .fill_way_i(fill_way), .fill_tag_i(fill_tag),
        .lkp_set_i(lkp_set), .lkp_tag_i(lkp_tag), .lkp_hit_o(lkp_hit), .lkp_ways_o(lkp_ways)
    );

    typedef struct packed {
        logic [1:0] src;
        logic [2:0] fset;
        logic       fway;
        logic [7:0] ftag;
        logic       pre_flush;
        logic [2:0] sset;
        logic [7:0] stag;
        logic       exp_busy;
        logic       exp_hit;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{2'd0, 3'd1, 1'b0, 8'h11, 1'b0, 3'd1, 8'h11, 1'b1, 1'b0},
        '{2'd1, 3'd2, 1'b1, 8'h22, 1'b0, 3'd2, 8'h23, 1'b0, 1'b1},
        '{2'd2, 3'd3, 1'b1, 8'h44, 1'b0, 3'd3, 8'h44, 1'b1, 1'b0},
        '{2'd1, 3'd5, 1'b0, 8'h55, 1'b0, 3'd4, 8'h55, 1'b0, 1'b1},
        '{2'd2, 3'd0, 1'b0, 8'h66, 1'b1, 3'd0, 8'h66, 1'b0, 1'b0},
        '{2'd0, 3'd6, 1'b1, 8'h7F, 1'b0, 3'd6, 8'h7F, 1'b1, 1'b0}
    };

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic fill(input logic [2:0] s, input logic w, input logic [7:0] t);
        fill_en = 1'b1; fill_set = s; fill_way = w; fill_tag = t;
        tick();
        fill_en = 1'b0;
    endtask

    task automatic look(input logic [2:0] s, input logic [7:0] t);
        lkp_set = s; lkp_tag = t;
        #1;
    endtask

    task automatic snoop(input int src, input logic [2:0] s, input logic [7:0] t);
        snp_valid[src] = 1'b1;
        snp_set[src*3 +: 3] = s;
        snp_tag[src*8 +: 8] = t;
    endtask

    task automatic do_flush();
        flush_i = 1'b1;
        tick();
        flush_i = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick();
        tick();
        rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog (R1-R10 run): actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        do_reset();

        // R1: idle after reset
        chk("R1", "busy after reset", 32'(busy), 32'h0);
        look(3'd0, 8'h00);
        chk("R1", "lookup after reset", 32'(lkp_hit), 32'h0);

        // Table walk: one snoop at a time (R2, R3, R5)
        foreach (VECS[i]) begin
            vec_t v;
            v = VECS[i];
            do_flush();
            fill(v.fset, v.fway, v.ftag);
            if (v.pre_flush) do_flush();
            look(v.fset, v.ftag);
            chk("R2", "hit after refill", 32'(lkp_hit), 32'(!v.pre_flush));
            if (!v.pre_flush) chk("R2", "way mask after refill", 32'(lkp_ways), 32'(2'b01 << v.fway));
            snoop(int'(v.src), v.sset, v.stag);
            tick();
            snp_valid = '0;
            chk(v.exp_busy ? "R3" : "R5", "busy after capture", 32'(busy[v.src]), 32'(v.exp_busy));
            tick();
            chk("R3", "busy released", 32'(busy), 32'h0);
            look(v.fset, v.ftag);
            chk(v.exp_busy ? "R3" : "R5", "line after snoop", 32'(lkp_hit), 32'(v.exp_hit));
        end

        // R4: every matching way cleared, other set untouched
        do_flush();
        fill(3'd4, 1'b0, 8'h33);
        fill(3'd4, 1'b1, 8'h33);
        fill(3'd7, 1'b0, 8'h33);
        look(3'd4, 8'h33);
        chk("R2", "both ways filled", 32'(lkp_ways), 32'h3);
        snoop(2, 3'd4, 8'h33);
        tick();
        snp_valid = '0;
        chk("R3", "dma busy", 32'(busy), 32'h4);
        tick();
        chk("R3", "dma released", 32'(busy), 32'h0);
        look(3'd4, 8'h33);
        chk("R4", "all ways cleared", 32'(lkp_ways), 32'h0);
        look(3'd7, 8'h33);
        chk("R4", "other set kept", 32'(lkp_hit), 32'h1);

        // R6: three simultaneous sources, pointer from reset at 0
        do_reset();
        fill(3'd1, 1'b0, 8'hA1);
        fill(3'd2, 1'b1, 8'hB2);
        fill(3'd3, 1'b0, 8'hC3);
        snoop(0, 3'd1, 8'hA1);
        snoop(1, 3'd2, 8'hB2);
        snoop(2, 3'd3, 8'hC3);
        tick();
        snp_valid = '0;
        chk("R6", "all busy", 32'(busy), 32'h7);
        tick();
        chk("R6", "first release", 32'(busy), 32'h6);
        look(3'd1, 8'hA1);
        chk("R7", "src0 cleared first", 32'(lkp_hit), 32'h0);
        look(3'd2, 8'hB2);
        chk("R6", "src1 still valid", 32'(lkp_hit), 32'h1);
        tick();
        chk("R6", "second release", 32'(busy), 32'h4);
        look(3'd2, 8'hB2);
        chk("R6", "src1 cleared", 32'(lkp_hit), 32'h0);
        tick();
        chk("R6", "third release", 32'(busy), 32'h0);
        look(3'd3, 8'hC3);
        chk("R6", "src2 cleared", 32'(lkp_hit), 32'h0);

        // R7: move pointer to 1, then sources 0 and 2 together
        fill(3'd1, 1'b0, 8'hA1);
        snoop(0, 3'd1, 8'hA1);
        tick();
        snp_valid = '0;
        tick();
        chk("R7", "lone source served", 32'(busy), 32'h0);
        fill(3'd2, 1'b1, 8'hB2);
        fill(3'd3, 1'b0, 8'hC3);
        fill(3'd5, 1'b1, 8'hD4);
        snoop(0, 3'd2, 8'hB2);
        snoop(2, 3'd3, 8'hC3);
        tick();
        snp_valid = '0;
        chk("R7", "two pending", 32'(busy), 32'h5);
        // R8: new snoop on source 0 while its busy is high
        snoop(0, 3'd5, 8'hD4);
        tick();
        snp_valid = '0;
        chk("R7", "src2 granted before src0", 32'(busy), 32'h1);
        look(3'd3, 8'hC3);
        chk("R7", "src2 line cleared", 32'(lkp_hit), 32'h0);
        look(3'd2, 8'hB2);
        chk("R7", "src0 line waits", 32'(lkp_hit), 32'h1);
        tick();
        chk("R7", "src0 released", 32'(busy), 32'h0);
        look(3'd2, 8'hB2);
        chk("R7", "src0 line cleared", 32'(lkp_hit), 32'h0);
        look(3'd5, 8'hD4);
        chk("R8", "ignored snoop left line", 32'(lkp_hit), 32'h1);
        tick();
        chk("R8", "no late entry", 32'(busy), 32'h0);
        look(3'd5, 8'hD4);
        chk("R8", "line still valid", 32'(lkp_hit), 32'h1);

        // R9: refill collides with the clear
        fill(3'd6, 1'b0, 8'hE5);
        snoop(1, 3'd6, 8'hE5);
        tick();
        snp_valid = '0;
        chk("R9", "entry pending", 32'(busy), 32'h2);
        fill(3'd6, 1'b0, 8'hE5);
        chk("R9", "released", 32'(busy), 32'h0);
        look(3'd6, 8'hE5);
        chk("R9", "clear beats refill", 32'(lkp_hit), 32'h0);

        // R10: flush with an entry pending
        fill(3'd0, 1'b1, 8'hF6);
        snoop(0, 3'd0, 8'hF6);
        tick();
        snp_valid = '0;
        chk("R10", "entry pending", 32'(busy), 32'h1);
        do_flush();
        chk("R10", "busy dropped", 32'(busy), 32'h0);
        look(3'd7, 8'h33);
        chk("R10", "valid bits wiped", 32'(lkp_hit), 32'h0);
        fill(3'd0, 1'b1, 8'hF6);
        tick();
        tick();
        look(3'd0, 8'hF6);
        chk("R10", "dropped entry never clears", 32'(lkp_hit), 32'h1);

        summary();
        $finish;
    end

endmodule